// File: doc/BRIEF.md
# RGMII In-Band Link Status Monitor

This block sits on the MAC side of an RGMII receive path, after the pins have been captured into single-rate 4-bit nibbles on the receive clock. While the receive data-valid strobe is low, the PHY places its link status on the four data lines during the gap between frames. The monitor watches those lines only in that gap. It waits until the same nibble has been seen for a set number of consecutive gap cycles, then decodes it into registered link, duplex and speed outputs.

A change pulse one clock long marks every cycle in which any registered output takes a new value, so downstream logic can reconfigure the MAC without polling. The status is always present on the wire from power-up, so the block needs no enable or handshake. The reserved speed code leaves the speed output unchanged, while the link and duplex fields of the same nibble still take effect.

Top module: `ibs_monitor`

## Requirements
- R1: After reset the outputs read link down (`link_up`=0), half duplex (`full_duplex`=0), speed code 00 (10 Mb/s), and `status_changed`=0.
- R2: A clock edge at which `rx_dv` is 1 never changes any output, whatever `rxd` carries.
- R3: An accepted gap nibble sets `full_duplex` to `rxd[3]` (0 half, 1 full).
- R4: An accepted gap nibble sets `link_speed` to `rxd[2:1]` when that code is 00 (10 Mb/s), 01 (100 Mb/s) or 10 (1000 Mb/s).
- R5: An accepted gap nibble sets `link_up` to `rxd[0]` (0 down, 1 up).
- R6: The speed code 11 is reserved. It leaves `link_speed` at its previous value, and `link_speed` never reads 11. The link and duplex fields of that nibble still update.
- R7: A gap nibble is accepted only at the STABLE_CYCLES-th consecutive edge (default 2) with `rx_dv` low and an unchanged `rxd`. A different nibble restarts the count from one, and an edge with `rx_dv` high restarts it from zero. The outputs change at the accepting edge.
- R8: `status_changed` is 1 for exactly the cycle in which the registered outputs differ from the previous cycle, and 0 otherwise.
- R9: When the nibble decodes to the values already held, acceptance happens again and again but no output changes and no pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_dv | input | 1 | Receive data valid; status is read only while low |
| rxd | input | 4 | Captured receive nibble |
| link_up | output | 1 | 1 when the link is up |
| full_duplex | output | 1 | 1 for full duplex, 0 for half |
| link_speed | output | 2 | 00 10 Mb/s, 01 100 Mb/s, 10 1000 Mb/s |
| status_changed | output | 1 | One-cycle pulse when any status output changes |

## Verification
The assertions assume that `rx_dv` and `rxd` are single-rate values that are stable around each rising receive-clock edge, and that any value of `rxd` may appear while `rx_dv` is high. The stimulus changes the inputs only on falling edges. It drives arbitrary frame data with `rx_dv` high, so that the check that frames cannot touch the status is actually exercised. The sweep walks every ordered pair of gap nibbles, so every field change, every reserved-code case and every no-change case is reached. Separate runs of alternating nibbles, and gaps cut short by a data-valid edge, test the restart rules of the stability count.

// File: rtl/ibs_pkg.sv
// Package: shared widths and types for the in-band status monitor.
// Assumes the nibble bit order: [3] duplex, [2:1] speed, [0] link.
package ibs_pkg;

    localparam int NIB_W = 4;

    // Speed code as carried on the data lines during the gap.
    typedef enum logic [1:0] {
        SPD_10   = 2'b00,
        SPD_100  = 2'b01,
        SPD_1000 = 2'b10,
        SPD_RSVD = 2'b11
    } speed_e;

    // Decoded status, packed in the same bit order as the nibble.
    typedef struct packed {
        logic   full_duplex;
        speed_e speed;
        logic   link_up;
    } status_t;

endpackage

// File: rtl/ibs_decode.sv
// Module: ibs_decode
// Splits one receive nibble into its duplex, speed and link fields and
// flags whether the speed code is usable. Purely combinational; assumes
// the caller decides whether the nibble was taken in the gap.
module ibs_decode
    import ibs_pkg::*;
(
    input  logic [NIB_W-1:0] nib,
    output status_t          fields,
    output logic             speed_ok
);

    // Map nibble bits onto the status fields.
    always_comb begin
        fields.full_duplex = nib[3];
        fields.speed       = speed_e'(nib[2:1]);
        fields.link_up     = nib[0];
    end

    // Only the three defined speed codes are usable.
    always_comb begin
        speed_ok = (nib[2:1] != SPD_RSVD);
    end

endmodule

// File: rtl/ibs_filter.sv
// Module: ibs_filter
// Stability filter: accepts a gap nibble once the same value has been seen
// at STABLE_CYCLES consecutive edges with the data-valid strobe low.
// A different nibble restarts the run at one; a frame edge clears it.
// Assumes inputs are already registered in the receive clock domain.
module ibs_filter
    import ibs_pkg::*;
#(
    parameter int STABLE_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gap,
    input  logic [NIB_W-1:0] nib,
    output logic             accept
);

    localparam int CNT_W = $clog2(STABLE_CYCLES + 1);

    generate
        if (STABLE_CYCLES <= 1) begin : g_direct
            // Every gap sample is accepted when no filtering is asked for.
            always_comb begin
                accept = gap;
            end
        end else begin : g_count
            localparam logic [CNT_W-1:0] RUN_MAX  = CNT_W'(STABLE_CYCLES);
            localparam logic [CNT_W-1:0] RUN_GATE = CNT_W'(STABLE_CYCLES - 1);

            logic [NIB_W-1:0] cand_q;
            logic [CNT_W-1:0] run_q;
            logic             same;

            // The current sample continues the run already in progress.
            always_comb begin
                same = (nib == cand_q) && (run_q != '0);
            end

            // Track the candidate nibble and how long it has held.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cand_q <= '0;
                    run_q  <= '0;
                end else if (!gap) begin
                    run_q  <= '0;
                end else if (same) begin
                    if (run_q != RUN_MAX) begin
                        run_q <= run_q + 1'b1;
                    end
                end else begin
                    cand_q <= nib;
                    run_q  <= CNT_W'(1);
                end
            end

            // This edge completes a run of the required length.
            always_comb begin
                accept = gap && same && (run_q >= RUN_GATE);
            end
        end
    endgenerate

endmodule

// File: rtl/ibs_hold.sv
// Module: ibs_hold
// Holds the registered status outputs and produces the change pulse.
// On acceptance, link and duplex always load; speed loads only when the
// code is usable. The pulse is registered with the outputs, so it is
// high in exactly the cycle the new values first appear.
module ibs_hold
    import ibs_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    accept,
    input  status_t fields,
    input  logic    speed_ok,
    output status_t held,
    output logic    changed
);

    status_t next_s;

    // Build the value the register takes on acceptance.
    always_comb begin
        next_s             = held;
        next_s.full_duplex = fields.full_duplex;
        next_s.link_up     = fields.link_up;
        if (speed_ok) begin
            next_s.speed = fields.speed;
        end
    end

    // Status register with link down, half duplex, 10 Mb/s at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '{full_duplex: 1'b0, speed: SPD_10, link_up: 1'b0};
        end else if (accept) begin
            held <= next_s;
        end
    end

    // One-cycle pulse aligned with a real change of the held value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            changed <= 1'b0;
        end else begin
            changed <= accept && (next_s != held);
        end
    end

endmodule

// File: rtl/ibs_monitor.sv
// Module: ibs_monitor (top)
// Extracts link, duplex and speed from the nibble a PHY sends between
// frames. Assumes rx_dv/rxd are already captured single-rate in the
// receive clock domain; status is always present, so no enable exists.
module ibs_monitor
    import ibs_pkg::*;
#(
    parameter int STABLE_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_dv,
    input  logic [3:0] rxd,
    output logic       link_up,
    output logic       full_duplex,
    output logic [1:0] link_speed,
    output logic       status_changed
);

    logic    gap;
    logic    accept;
    logic    speed_ok;
    status_t fields;
    status_t held;

    // The data lines carry status only while the valid strobe is low.
    always_comb begin
        gap = !rx_dv;
    end

    ibs_decode u_decode (
        .nib      (rxd),
        .fields   (fields),
        .speed_ok (speed_ok)
    );

    ibs_filter #(
        .STABLE_CYCLES (STABLE_CYCLES)
    ) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .gap    (gap),
        .nib    (rxd),
        .accept (accept)
    );

    ibs_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .fields   (fields),
        .speed_ok (speed_ok),
        .held     (held),
        .changed  (status_changed)
    );

    // Drive the flat output ports from the held status.
    always_comb begin
        link_up     = held.link_up;
        full_duplex = held.full_duplex;
        link_speed  = held.speed;
    end

endmodule

// File: rtl/ibs_monitor_chk.sv
// Module: ibs_monitor_chk
// Property checker for ibs_monitor, attached by bind. Observes ports only.
module ibs_monitor_chk #(
    parameter int STABLE_CYCLES = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_dv,
    input logic [3:0] rxd,
    input logic       link_up,
    input logic       full_duplex,
    input logic [1:0] link_speed,
    input logic       status_changed
);

    logic [1:0] age_q;
    logic [3:0] outs;

    // Count cycles since reset so $past never reaches before it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= 2'd0;
        end else if (age_q != 2'd2) begin
            age_q <= age_q + 2'd1;
        end
    end

    // Gather the status outputs into one vector.
    always_comb begin
        outs = {full_duplex, link_speed, link_up};
    end

    // R2: an edge taken inside a frame leaves every output as it was.
    a_r2_frame_no_update: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0 && $past(rx_dv)) |-> $stable(outs));

    // R6: the reserved speed code never reaches the output.
    a_r6_no_reserved_speed: assert property (@(posedge clk) disable iff (!rst_n)
        link_speed != 2'b11);

    // R8: a pulse only comes with a real change.
    a_r8_pulse_has_change: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0 && status_changed) |-> (outs != $past(outs)));

    // R8: every change carries a pulse.
    a_r8_change_has_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0 && outs != $past(outs)) |-> status_changed);

    generate
        if (STABLE_CYCLES >= 2) begin : g_run
            // R7: a change needs two gap edges in a row with the same nibble.
            a_r7_two_same_gap: assert property (@(posedge clk) disable iff (!rst_n)
                (age_q == 2'd2 && outs != $past(outs)) |->
                (!$past(rx_dv) && !$past(rx_dv, 2) && $past(rxd) == $past(rxd, 2)));
        end
    endgenerate

endmodule

bind ibs_monitor ibs_monitor_chk #(
    .STABLE_CYCLES (STABLE_CYCLES)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_dv          (rx_dv),
    .rxd            (rxd),
    .link_up        (link_up),
    .full_duplex    (full_duplex),
    .link_speed     (link_speed),
    .status_changed (status_changed)
);

// File: tb/ibs_monitor_bench.sv
`timescale 1ns/1ps
module ibs_monitor_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_dv = 1'b1;
    logic [3:0] rxd = 4'h0;
    logic       link_up, full_duplex, status_changed;
    logic [1:0] link_speed;

    int checks = 0;
    int errors = 0;
    logic       e_link = 1'b0, e_dup = 1'b0;
    logic [1:0] e_spd = 2'b00;

    always #2.5 clk = ~clk;

    ibs_monitor u_ibs_monitor (
        .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .rxd(rxd),
        .link_up(link_up), .full_duplex(full_duplex),
        .link_speed(link_speed), .status_changed(status_changed)
    );

    // Compare outputs {dup, spd, link, pulse} with the expected values.
    task automatic check(string tag, logic exp_pulse);
        logic [4:0] act, exp;
        act = {full_duplex, link_speed, link_up, status_changed};
        exp = {e_dup, e_spd, e_link, exp_pulse};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b (dup,spd,link,pulse)", tag, act, exp);
        end
    endtask

    // Drive one edge from a falling edge, then return at the next falling edge.
    task automatic cyc(logic dv, logic [3:0] d);
        rx_dv = dv;
        rxd   = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Expected effect of accepting nibble v; returns whether anything changes.
    function automatic logic model(logic [3:0] v);
        logic [1:0] ns;
        logic       ch;
        ns = (v[2:1] == 2'b11) ? e_spd : v[2:1];
        ch = (v[3] != e_dup) || (v[0] != e_link) || (ns != e_spd);
        e_dup  = v[3];
        e_link = v[0];
        e_spd  = ns;
        return ch;
    endfunction

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic ch;
        @(negedge clk);
        cyc(1'b1, 4'hF);
        cyc(1'b1, 4'hF);
        rst_n = 1'b1;
        cyc(1'b1, 4'hF);
        check("R1 reset state", 1'b0);

        // R2: frame data of every value must not touch the status.
        for (int i = 0; i < 16; i++) begin
            cyc(1'b1, 4'(i));
            check("R2 frame data ignored", 1'b0);
        end

        // Exhaustive sweep over all ordered pairs of gap nibbles.
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                cyc(1'b1, 4'(a));
                cyc(1'b0, 4'(a));
                cyc(1'b0, 4'(a));
                ch = model(4'(a));
                check("R3 R4 R5 R6 set first nibble", ch);
                cyc(1'b1, ~4'(b));
                check("R2 frame edge holds status", 1'b0);
                cyc(1'b0, 4'(b));
                check("R7 single gap edge not accepted", 1'b0);
                cyc(1'b0, 4'(b));
                ch = model(4'(b));
                check("R3 R4 R5 R6 R8 decode on second gap edge", ch);
                cyc(1'b0, 4'(b));
                check("R9 repeat gives no pulse", 1'b0);
            end
        end

        // R7: alternating nibbles never build a run.
        cyc(1'b1, 4'h0);
        for (int i = 0; i < 10; i++) begin
            cyc(1'b0, (i % 2 == 0) ? 4'h9 : 4'h6);
            check("R7 alternating nibbles rejected", 1'b0);
        end

        // R7: a frame edge in the middle of a run restarts it from zero.
        cyc(1'b0, 4'h2);
        check("R7 run start", 1'b0);
        cyc(1'b1, 4'h2);
        check("R7 frame edge breaks run", 1'b0);
        cyc(1'b0, 4'h2);
        check("R7 run restarted", 1'b0);
        cyc(1'b0, 4'h2);
        ch = model(4'h2);
        check("R7 R4 accepted after restart", ch);

        // R6: reserved speed with new link and duplex still updates them.
        cyc(1'b0, 4'hF);
        cyc(1'b0, 4'hF);
        ch = model(4'hF);
        check("R6 reserved holds speed", ch);
        cyc(1'b0, 4'hF);
        check("R9 R8 pulse lasts one cycle", 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule